// File: doc/BRIEF.md
# Multi-agent interrupt notification controller

This block lets a fixed set of agents raise doorbell-style notifications at one another. Each agent owns a 32-byte register window on a simple memory-mapped bus. When an agent writes a bit mask to its trigger register, it raises a notification toward every agent whose bit is set in that mask. The target sees a status bit for that source. If the source is unmasked, the target's interrupt line goes high. The sender sees the same notification as a pending bit in its observation register, so it can poll until the target acknowledges.

Agent `k` owns bit position `k` in every per-source and per-target field. Its window starts at byte address `k * 0x20`. A single pending flop per (target, source) pair is the one record of a notification. The target's status register is a row of that matrix, and the sender's observation register is a column of it. An acknowledge therefore clears both views in the same edge.

The bus accepts one access per cycle. There is no back-pressure: every request is taken in the cycle it is presented. A read returns its data exactly one cycle after the request, marked by `rd_valid`.

Top module: `ipi_ctrl`

## Requirements
- R1: After reset every source is masked for every agent (mask reads all ones in bits N-1:0), every status and observation register reads zero, and all `irq` lines are low.
- R2: A write of value V to agent S's trigger register (offset 0x00) sets bit S of the status register (offset 0x10) of every agent T for which V[T] is 1. Other status bits are left unchanged.
- R3: Bit T of agent S's observation register (offset 0x04) reads 1 exactly while bit S of agent T's status register is 1.
- R4: Writing V to agent T's status register clears each status bit whose bit in V is 1 and leaves the rest unchanged. The matching observation bits of the source agents clear together with it.
- R5: Writing ones to the disable register (offset 0x1C) sets the matching mask bits. Writing ones to the enable register (offset 0x18) clears them. Zero bits leave the mask unchanged. The mask reads back at offset 0x14, where 1 means masked.
- R6: `irq[T]` is high exactly when agent T has a status bit set whose mask bit is 0. It follows every status and mask change from the cycle after the write.
- R7: Reads of the trigger, enable and disable registers return zero. Writes to the observation and mask registers change nothing.
- R8: Offsets other than the six above, byte addresses whose agent field (address bits above bit 4) is N or more, and misaligned offsets all read zero and ignore writes.
- R9: A read request yields `rd_valid` high for exactly one cycle, in the cycle after the request, together with its data. A write never yields `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access present this cycle, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: agent field above bit 4, register offset in bits 4:0 |
| req_wdata | input | DATA_W | Write data, bit k addresses agent k |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | DATA_W | Read data, zero when `rd_valid` is low |
| irq | output | N_AGENTS | Per-agent interrupt, high while an unmasked status bit is set |

## Verification
A write is taken at the rising edge that sees it. The status, observation, mask and `irq` values that result are due in the cycle after that edge. Read data is due in the same cycle as `rd_valid`, one cycle after the request. The bench drives on falling edges and keeps a queue of expected read values; a monitor pops that queue at every falling edge on which `rd_valid` is high. It checks `irq` and the absence of `rd_valid` at the first falling edge after each write. Any `rd_valid` with an empty queue is a failure, and so is an entry left in the queue at the end.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WIN_BITS = 5;

  localparam logic [WIN_BITS-1:0] OFF_TRIG = 5'h00;
  localparam logic [WIN_BITS-1:0] OFF_OBS  = 5'h04;
  localparam logic [WIN_BITS-1:0] OFF_STAT = 5'h10;
  localparam logic [WIN_BITS-1:0] OFF_MASK = 5'h14;
  localparam logic [WIN_BITS-1:0] OFF_EN   = 5'h18;
  localparam logic [WIN_BITS-1:0] OFF_DIS  = 5'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TRIG,
    SEL_OBS,
    SEL_STAT,
    SEL_MASK,
    SEL_EN,
    SEL_DIS
  } ipi_sel_e;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int ADDR_W   = 12,
  parameter int AGW      = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [AGW-1:0]    agent,
  output ipi_sel_e          sel
);
  localparam int FW = ADDR_W - WIN_BITS;

  logic [FW-1:0] field;
  logic          in_range;

  assign field    = addr[ADDR_W-1:WIN_BITS];
  assign agent    = field[AGW-1:0];
  assign in_range = field < FW'(N_AGENTS);

  always_comb begin
    sel = SEL_NONE;
    if (in_range) begin
      unique case (addr[WIN_BITS-1:0])
        OFF_TRIG: sel = SEL_TRIG;
        OFF_OBS:  sel = SEL_OBS;
        OFF_STAT: sel = SEL_STAT;
        OFF_MASK: sel = SEL_MASK;
        OFF_EN:   sel = SEL_EN;
        OFF_DIS:  sel = SEL_DIS;
        default:  sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ipi_pend_matrix.sv
module ipi_pend_matrix #(
  parameter int N_AGENTS = 4,
  parameter int AGW      = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               trig_we,
  input  logic [AGW-1:0]                     trig_src,
  input  logic [N_AGENTS-1:0]                trig_bits,
  input  logic                               ack_we,
  input  logic [AGW-1:0]                     ack_dst,
  input  logic [N_AGENTS-1:0]                ack_bits,
  output logic [N_AGENTS-1:0][N_AGENTS-1:0]  stat
);
  // stat[t][s]: notification from source s pending at target t
  for (genvar t = 0; t < N_AGENTS; t++) begin : g_tgt
    for (genvar s = 0; s < N_AGENTS; s++) begin : g_src
      logic set_c;
      logic clr_c;
      assign set_c = trig_we && (trig_src == AGW'(s)) && trig_bits[t];
      assign clr_c = ack_we && (ack_dst == AGW'(t)) && ack_bits[s];

      always_ff @(posedge clk) begin
        if (!rst_n)     stat[t][s] <= 1'b0;
        else if (set_c) stat[t][s] <= 1'b1;
        else if (clr_c) stat[t][s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipi_mask_bank.sv
module ipi_mask_bank #(
  parameter int N_AGENTS = 4,
  parameter int AGW      = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               en_we,
  input  logic                               dis_we,
  input  logic [AGW-1:0]                     agent,
  input  logic [N_AGENTS-1:0]                bits,
  output logic [N_AGENTS-1:0][N_AGENTS-1:0]  mask
);
  for (genvar t = 0; t < N_AGENTS; t++) begin : g_row
    logic hit;
    assign hit = (agent == AGW'(t));

    always_ff @(posedge clk) begin
      if (!rst_n)              mask[t] <= '1;
      else if (en_we && hit)   mask[t] <= mask[t] & ~bits;
      else if (dis_we && hit)  mask[t] <= mask[t] | bits;
    end
  end
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic [N_AGENTS-1:0] irq
);
  localparam int AGW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

  logic [AGW-1:0]                    agent;
  ipi_sel_e                          sel;
  logic [N_AGENTS-1:0][N_AGENTS-1:0] stat_q;
  logic [N_AGENTS-1:0][N_AGENTS-1:0] mask_q;
  logic [N_AGENTS-1:0]               wbits;
  logic                              wr;
  logic                              rd;
  logic [DATA_W-1:0]                 rd_next;

  assign wbits = req_wdata[N_AGENTS-1:0];
  assign wr    = req_valid && req_write;
  assign rd    = req_valid && !req_write;

  if (DATA_W > N_AGENTS) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^req_wdata[DATA_W-1:N_AGENTS];
  end

  ipi_addr_decode #(.N_AGENTS(N_AGENTS), .ADDR_W(ADDR_W), .AGW(AGW)) u_dec (
    .addr  (req_addr),
    .agent (agent),
    .sel   (sel)
  );

  ipi_pend_matrix #(.N_AGENTS(N_AGENTS), .AGW(AGW)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_we   (wr && (sel == SEL_TRIG)),
    .trig_src  (agent),
    .trig_bits (wbits),
    .ack_we    (wr && (sel == SEL_STAT)),
    .ack_dst   (agent),
    .ack_bits  (wbits),
    .stat      (stat_q)
  );

  ipi_mask_bank #(.N_AGENTS(N_AGENTS), .AGW(AGW)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_we  (wr && (sel == SEL_EN)),
    .dis_we (wr && (sel == SEL_DIS)),
    .agent  (agent),
    .bits   (wbits),
    .mask   (mask_q)
  );

  for (genvar t = 0; t < N_AGENTS; t++) begin : g_irq
    assign irq[t] = |(stat_q[t] & ~mask_q[t]);
  end

  // read view: status is a row of the matrix, observation is a column
  always_comb begin
    rd_next = '0;
    for (int t = 0; t < N_AGENTS; t++) begin
      for (int s = 0; s < N_AGENTS; s++) begin
        if (sel == SEL_OBS && agent == AGW'(s)) rd_next[t] = stat_q[t][s];
      end
      if (sel == SEL_STAT && agent == AGW'(t)) rd_next[N_AGENTS-1:0] = stat_q[t];
      if (sel == SEL_MASK && agent == AGW'(t)) rd_next[N_AGENTS-1:0] = mask_q[t];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      rd_data  <= rd ? rd_next : '0;
    end
  end
endmodule

// File: rtl/ipi_ctrl_checker.sv
module ipi_ctrl_checker
  import ipi_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               req_valid,
  input logic                               req_write,
  input logic [ADDR_W-1:0]                  req_addr,
  input logic [DATA_W-1:0]                  req_wdata,
  input logic                               rd_valid,
  input logic [DATA_W-1:0]                  rd_data,
  input logic [N_AGENTS-1:0][N_AGENTS-1:0]  stat,
  input logic [N_AGENTS-1:0][N_AGENTS-1:0]  mask
);
  localparam int FW = ADDR_W - WIN_BITS;

  logic [FW-1:0]       fld;
  logic [WIN_BITS-1:0] off;
  logic                wr;
  logic                rd;
  logic                mapped;
  logic                unused_w;

  assign fld      = req_addr[ADDR_W-1:WIN_BITS];
  assign off      = req_addr[WIN_BITS-1:0];
  assign wr       = req_valid && req_write;
  assign rd       = req_valid && !req_write;
  assign mapped   = (fld < FW'(N_AGENTS)) &&
                    (off == OFF_TRIG || off == OFF_OBS || off == OFF_STAT ||
                     off == OFF_MASK || off == OFF_EN || off == OFF_DIS);
  assign unused_w = ^req_wdata;

  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
  assert_no_spurious_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rd_valid);
  assert_zero_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (off == OFF_TRIG || off == OFF_EN || off == OFF_DIS)) |=> (rd_data == '0));
  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !mapped) |=> (rd_data == '0));
  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !mapped) |=> ($stable(stat) && $stable(mask)));
  assert_ro_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (off == OFF_OBS || off == OFF_MASK)) |=> ($stable(stat) && $stable(mask)));

  for (genvar t = 0; t < N_AGENTS; t++) begin : g_t
    for (genvar s = 0; s < N_AGENTS; s++) begin : g_s
      assert_trig_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && fld == FW'(s) && off == OFF_TRIG && req_wdata[t]) |=> stat[t][s]);
      assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && fld == FW'(t) && off == OFF_STAT && req_wdata[s]) |=> !stat[t][s]);
      assert_dis_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && fld == FW'(t) && off == OFF_DIS && req_wdata[s]) |=> mask[t][s]);
      assert_en_unmasks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && fld == FW'(t) && off == OFF_EN && req_wdata[s]) |=> !mask[t][s]);
    end
  end
endmodule

bind ipi_ctrl ipi_ctrl_checker #(
  .N_AGENTS (N_AGENTS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .stat      (stat_q),
  .mask      (mask_q)
);

// File: tb/ipi_ctrl_bench.sv
module ipi_ctrl_bench;
  localparam int N  = 4;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [N-1:0]  irq;

  always #10 clk = ~clk;

  ipi_ctrl #(.N_AGENTS(N), .ADDR_W(AW), .DATA_W(DW)) u_ipi_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  logic [N-1:0]  m_stat [N];
  logic [N-1:0]  m_mask [N];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_read(int ag, int off);
    logic [DW-1:0] v = '0;
    if (ag >= N) return '0;
    case (off)
      'h04: for (int t = 0; t < N; t++) v[t] = m_stat[t][ag];
      'h10: v[N-1:0] = m_stat[ag];
      'h14: v[N-1:0] = m_mask[ag];
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [DW-1:0] model_irq();
    logic [DW-1:0] v = '0;
    for (int t = 0; t < N; t++) v[t] = |(m_stat[t] & ~m_mask[t]);
    return v;
  endfunction

  task automatic model_write(int ag, int off, logic [DW-1:0] d);
    if (ag >= N) return;
    case (off)
      'h00: for (int t = 0; t < N; t++) if (d[t]) m_stat[t][ag] = 1'b1;
      'h10: m_stat[ag] = m_stat[ag] & ~d[N-1:0];
      'h18: m_mask[ag] = m_mask[ag] & ~d[N-1:0];
      'h1C: m_mask[ag] = m_mask[ag] | d[N-1:0];
      default: ;
    endcase
  endtask

  // driver: write, then check irq and absence of a read response
  task automatic bus_wr(int ag, int off, logic [DW-1:0] d, string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = AW'(ag * 32 + off); req_wdata = d;
    model_write(ag, off, d);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R9 write gives no rd_valid", {31'b0, rd_valid}, '0);
    check({req, " irq after write (R6)"}, {28'b0, irq}, model_irq());
  endtask

  // driver: read, expected value goes to the scoreboard queue
  task automatic bus_rd(int ag, int off, string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0;
    req_addr = AW'(ag * 32 + off); req_wdata = '0;
    exp_q.push_back(model_read(ag, off));
    tag_q.push_back(req);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 unexpected rd_valid actual=1 expected=0");
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < N; t++) begin m_stat[t] = '0; m_mask[t] = '1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 irq after reset", {28'b0, irq}, '0);
    check("R9 no rd_valid after reset", {31'b0, rd_valid}, '0);
    for (int a = 0; a < N; a++) begin
      bus_rd(a, 'h14, "R1 mask all ones");
      bus_rd(a, 'h10, "R1 status zero");
      bus_rd(a, 'h04, "R1 observation zero");
    end

    bus_wr(0, 'h00, 32'h6, "R2 trigger 0->1,2");
    bus_rd(1, 'h10, "R2 status of agent 1");
    bus_rd(2, 'h10, "R2 status of agent 2");
    bus_rd(3, 'h10, "R2 untargeted status");
    bus_rd(0, 'h04, "R3 observation of agent 0");

    bus_wr(1, 'h18, 32'h1, "R5 enable source 0 at agent 1");
    bus_rd(1, 'h14, "R5 mask after enable");
    bus_wr(1, 'h18, 32'h0, "R5 zero enable");
    bus_rd(1, 'h14, "R5 mask unchanged by zero write");
    bus_wr(1, 'h1C, 32'h0, "R5 zero disable");
    bus_rd(1, 'h14, "R5 mask unchanged by zero disable");

    bus_wr(3, 'h00, 32'h2, "R2 trigger 3->1");
    bus_rd(1, 'h10, "R2 status accumulates");
    bus_rd(3, 'h04, "R3 observation of agent 3");
    bus_wr(1, 'h18, 32'hF, "R5 enable all at agent 1");

    bus_wr(1, 'h10, 32'h1, "R4 ack source 0 at agent 1");
    bus_rd(1, 'h10, "R4 status after partial ack");
    bus_rd(0, 'h04, "R4 sender observation clears");
    bus_rd(3, 'h04, "R4 other sender keeps pending");

    bus_wr(1, 'h1C, 32'h8, "R6 disable source 3 masks irq");
    bus_rd(1, 'h14, "R5 mask after disable");

    bus_rd(0, 'h00, "R7 trigger reads zero");
    bus_rd(1, 'h18, "R7 enable reads zero");
    bus_rd(1, 'h1C, "R7 disable reads zero");
    bus_wr(0, 'h04, 32'hF, "R7 write to observation");
    bus_wr(2, 'h14, 32'h0, "R7 write to mask");
    bus_rd(0, 'h04, "R7 observation unchanged");
    bus_rd(2, 'h14, "R7 mask unchanged");

    bus_wr(0, 'h08, 32'hF, "R8 unmapped offset write");
    bus_wr(4, 'h00, 32'hF, "R8 out-of-range agent trigger");
    bus_wr(2, 'h12, 32'hF, "R8 misaligned status write");
    bus_rd(0, 'h08, "R8 unmapped offset reads zero");
    bus_rd(4, 'h10, "R8 out-of-range agent reads zero");
    for (int a = 0; a < N; a++) bus_rd(a, 'h10, "R8 status untouched");

    bus_wr(2, 'h18, 32'hF, "R6 enable all at agent 2");
    bus_wr(2, 'h00, 32'h4, "R2 self trigger");
    bus_rd(2, 'h10, "R2 self status");
    bus_wr(2, 'h10, 32'hF, "R4 ack all at agent 2");
    bus_wr(1, 'h10, 32'hF, "R4 ack all at agent 1");
    bus_rd(3, 'h04, "R3 observation empty after acks");

    repeat (3) @(negedge clk);
    check("R9 every read answered", DW'(exp_q.size()), '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule